// File: doc/BRIEF.md
# Ring Queue Doorbell and Pointer Tracker

This block keeps the pointer state for a set of paired submission and completion ring queues used by a host-driven storage controller. Software rings a doorbell by writing a 32-bit word into a window of register addresses. Each queue has two doorbells, placed one after the other, one for each direction. A submission doorbell moves that queue's tail. A completion doorbell moves that completion queue's head. Separate internal agents consume submission entries through a fetch strobe and post completions through a valid/ready port. The block returns the slot index to use and the status halfword to write. That halfword carries a phase tag that flips each time the completion ring wraps.

Queues are brought into existence through a configuration strobe that carries the zero-based size, the completion queue a submission queue is bound to, and whether interrupts are enabled. A head doorbell on a completion queue that was full produces a restart pulse for that queue and for every submission queue bound to it. A head update that leaves unconsumed entries produces an interrupt request if that queue has interrupts enabled. Queue 0 is the administrative pair. It is handled like any other queue.

Completion posting uses valid/ready. `post_ready` is low while the selected completion queue is full or does not exist. A post is taken only in a cycle where `post_valid` and `post_ready` are both high. The status and slot outputs are valid during that same cycle. Doorbell writes, configuration and fetch strobes have no back-pressure.

Top module: `qdb_tracker`

## Requirements
- R1: After reset no queue exists: every `sq_empty` bit is 1, every `cq_full` bit is 0, `post_ready` is 0, and no irq or restart pulse is high.
- R2: A doorbell write at address A ≥ 0x1000 uses offset O = A − 0x1000. O[1:0] must be 0, otherwise the write is ignored. The queue id is O >> 3. O[2] = 1 selects the completion-head doorbell and O[2] = 0 selects the submission-tail doorbell. Only data bits [15:0] are used.
- R3: A doorbell write to a queue that does not exist, or whose value is greater than or equal to that queue's size, changes nothing.
- R4: Configuring a queue with zero-based size N gives it N+1 slots, clears its head and tail to 0, and sets the completion phase tag to 1.
- R5: A submission queue is empty when head equals tail. A fetch strobe returns the head slot on `fetch_slot` and advances the head, wrapping to 0 at the size. A fetch on an empty queue is ignored.
- R6: A completion queue is full when (tail+1) mod size equals head. `post_ready` is low while the selected queue is full or absent.
- R7: An accepted post uses slot `cqe_slot` = tail and status halfword `cqe_status` = {code[14:0], phase}. The tail then advances, wrapping to 0 at the size, and the phase toggles on every wrap.
- R8: A valid head doorbell on a completion queue that was full just before the write pulses `restart_cq` for that queue and `restart_sq` for every submission queue bound to it, for one cycle, in the cycle after the write.
- R9: A valid head doorbell pulses `irq_req` for that queue in the next cycle exactly when interrupts are enabled and the new head differs from the tail.
- R10: `sq_empty` and `cq_full` are registered and reflect a state change one cycle after the change takes effect. A head doorbell and a post to the same queue in the same cycle are both applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Doorbell write strobe |
| wr_addr | input | AW | Doorbell byte address |
| wr_data | input | 32 | Doorbell write data |
| cfg_en | input | 1 | Queue configuration strobe |
| cfg_is_cq | input | 1 | 1: configure completion queue, 0: submission queue |
| cfg_qid | input | QI | Queue id to configure |
| cfg_qsize | input | QW | Zero-based queue size |
| cfg_cqid | input | QI | Completion queue bound to a submission queue |
| cfg_ien | input | 1 | Interrupt enable for a completion queue |
| fetch_en | input | 1 | Consume one submission entry |
| fetch_sqid | input | QI | Submission queue to consume from |
| fetch_slot | output | QW | Current head slot of `fetch_sqid` |
| post_valid | input | 1 | Completion post request |
| post_ready | output | 1 | Completion queue can take a post |
| post_cqid | input | QI | Target completion queue |
| post_code | input | SW | Completion status code |
| cqe_status | output | SW+1 | Status halfword {code, phase} |
| cqe_slot | output | QW | Slot the entry is written to |
| sq_empty | output | NQ | Registered per-queue empty flags |
| cq_full | output | NQ | Registered per-queue full flags |
| irq_req | output | NQ | Per completion queue interrupt request pulse |
| restart_cq | output | NQ | Per completion queue posting restart pulse |
| restart_sq | output | NQ | Per submission queue fetch restart pulse |

## Verification
A four-slot completion queue is posted into until it is full, partly drained by a head doorbell, and posted into again across the wrap. This separates correct phase toggling and full detection from off-by-one tail arithmetic. Head doorbells are issued from full and from non-full states, with interrupts both enabled and disabled. These cases tell the restart condition apart from the interrupt condition and show that restarts reach only the bound submission queues. Misaligned, out-of-range and oversized doorbell values are shown to leave the queue flags unchanged. A doorbell issued in the same cycle as a post shows that neither update is lost.

// File: rtl/qdb_pkg.sv
package qdb_pkg;
  typedef enum logic [1:0] {
    DB_NONE    = 2'd0,
    DB_SQ_TAIL = 2'd1,
    DB_CQ_HEAD = 2'd2
  } db_kind_t;
endpackage

// File: rtl/qdb_decode.sv
module qdb_decode
  import qdb_pkg::*;
#(
  parameter int AW = 16,
  parameter int NQ = 64,
  parameter int QI = 6,
  parameter logic [AW-1:0] BASE = 16'h1000
) (
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  output db_kind_t      kind,
  output logic [QI-1:0] qid
);
  logic [AW-1:0] off;
  logic          in_rng;

  always_comb begin
    off    = wr_addr - BASE;
    in_rng = (wr_addr >= BASE) && ((32'(off) >> 3) < NQ);
    qid    = off[QI+2:3];
    if (!wr_en || !in_rng || off[1:0] != 2'b00) kind = DB_NONE;
    else if (off[2])                            kind = DB_CQ_HEAD;
    else                                        kind = DB_SQ_TAIL;
  end
endmodule

// File: rtl/qdb_sq_slot.sv
module qdb_sq_slot #(
  parameter int QW = 12,
  parameter int QI = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [QW-1:0] cfg_qsize,
  input  logic [QI-1:0] cfg_cqid,
  input  logic          tl_we,
  input  logic [15:0]   tl_val,
  input  logic          fetch_we,
  output logic [QW-1:0] head,
  output logic [QI-1:0] bind_cq,
  output logic          live,
  output logic          empty_q
);
  localparam int CW = 17;
  logic [QW-1:0] size, tail, head_inc;
  logic          is_empty, tl_ok;

  always_comb begin
    is_empty = (head == tail);
    head_inc = (head + 1'b1 == size) ? '0 : head + 1'b1;
    tl_ok    = tl_we && live && (CW'(tl_val) < CW'(size));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live <= 1'b0; size <= '0; head <= '0; tail <= '0;
      bind_cq <= '0; empty_q <= 1'b1;
    end else begin
      empty_q <= !live || is_empty;
      if (cfg_we) begin
        live <= 1'b1; size <= cfg_qsize + 1'b1;
        head <= '0; tail <= '0; bind_cq <= cfg_cqid;
      end else begin
        if (tl_ok) tail <= tl_val[QW-1:0];
        if (fetch_we && live && !is_empty) head <= head_inc;
      end
    end
  end

  // R5: the head stays inside the ring
  assert_head_in_ring_R5: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> head < size);
  // R5: the head moves only because of a fetch
  assert_head_moves_on_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(live) && !$past(cfg_we) && head != $past(head)) |-> $past(fetch_we));
endmodule

// File: rtl/qdb_cq_slot.sv
module qdb_cq_slot #(
  parameter int QW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [QW-1:0] cfg_qsize,
  input  logic          cfg_ien,
  input  logic          hd_we,
  input  logic [15:0]   hd_val,
  input  logic          post_we,
  output logic [QW-1:0] tail,
  output logic          phase,
  output logic          live,
  output logic          full_now,
  output logic          full_q,
  output logic          irq_q,
  output logic          restart_q
);
  localparam int CW = 17;
  logic [QW-1:0] size, head, tail_inc, tail_nx;
  logic          ien, wrap, hd_ok;

  always_comb begin
    wrap     = (tail + 1'b1 == size);
    tail_inc = wrap ? '0 : tail + 1'b1;
    full_now = live && (tail_inc == head);
    tail_nx  = (post_we && live && !full_now) ? tail_inc : tail;
    hd_ok    = hd_we && live && (CW'(hd_val) < CW'(size));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live <= 1'b0; size <= '0; head <= '0; tail <= '0; phase <= 1'b1;
      ien <= 1'b0; full_q <= 1'b0; irq_q <= 1'b0; restart_q <= 1'b0;
    end else begin
      full_q <= full_now;
      if (cfg_we) begin
        live <= 1'b1; size <= cfg_qsize + 1'b1; head <= '0; tail <= '0;
        phase <= 1'b1; ien <= cfg_ien; irq_q <= 1'b0; restart_q <= 1'b0;
      end else begin
        tail      <= tail_nx;
        if (post_we && live && !full_now && wrap) phase <= ~phase;
        if (hd_ok) head <= hd_val[QW-1:0];
        restart_q <= hd_ok && full_now;
        irq_q     <= hd_ok && ien && (hd_val[QW-1:0] != tail_nx);
      end
    end
  end

  // R7: the tail stays inside the ring
  assert_tail_in_ring_R7: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> tail < size);
  // R6: the port never offers a post to a full ring
  assert_no_post_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (post_we && !cfg_we) |-> !full_now);
  // R7: the phase changes only when the tail lands on slot 0
  assert_phase_on_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(live) && !$past(cfg_we) && phase != $past(phase)) |-> tail == '0);
  // R9: an interrupt request follows a head doorbell
  assert_irq_after_doorbell_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(hd_we));
endmodule

// File: rtl/qdb_tracker.sv
module qdb_tracker
  import qdb_pkg::*;
#(
  parameter int NQ = 64,
  parameter int QW = 12,
  parameter int AW = 16,
  parameter int SW = 15,
  parameter int QI = $clog2(NQ)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic          cfg_en,
  input  logic          cfg_is_cq,
  input  logic [QI-1:0] cfg_qid,
  input  logic [QW-1:0] cfg_qsize,
  input  logic [QI-1:0] cfg_cqid,
  input  logic          cfg_ien,
  input  logic          fetch_en,
  input  logic [QI-1:0] fetch_sqid,
  output logic [QW-1:0] fetch_slot,
  input  logic          post_valid,
  output logic          post_ready,
  input  logic [QI-1:0] post_cqid,
  input  logic [SW-1:0] post_code,
  output logic [SW:0]   cqe_status,
  output logic [QW-1:0] cqe_slot,
  output logic [NQ-1:0] sq_empty,
  output logic [NQ-1:0] cq_full,
  output logic [NQ-1:0] irq_req,
  output logic [NQ-1:0] restart_cq,
  output logic [NQ-1:0] restart_sq
);
  db_kind_t      kind;
  logic [QI-1:0] db_qid;
  logic [QW-1:0] sq_head [NQ];
  logic [QI-1:0] sq_bind [NQ];
  logic [QW-1:0] cq_tail [NQ];
  logic [NQ-1:0] sq_live, cq_live, cq_phase, cq_full_now;

  qdb_decode #(.AW(AW), .NQ(NQ), .QI(QI)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .kind(kind), .qid(db_qid));

  for (genvar q = 0; q < NQ; q++) begin : g_q
    qdb_sq_slot #(.QW(QW), .QI(QI)) u_sq (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_en && !cfg_is_cq && cfg_qid == QI'(q)),
      .cfg_qsize(cfg_qsize), .cfg_cqid(cfg_cqid),
      .tl_we(kind == DB_SQ_TAIL && db_qid == QI'(q)), .tl_val(wr_data[15:0]),
      .fetch_we(fetch_en && fetch_sqid == QI'(q)),
      .head(sq_head[q]), .bind_cq(sq_bind[q]), .live(sq_live[q]),
      .empty_q(sq_empty[q]));

    qdb_cq_slot #(.QW(QW)) u_cq (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_en && cfg_is_cq && cfg_qid == QI'(q)),
      .cfg_qsize(cfg_qsize), .cfg_ien(cfg_ien),
      .hd_we(kind == DB_CQ_HEAD && db_qid == QI'(q)), .hd_val(wr_data[15:0]),
      .post_we(post_valid && post_ready && post_cqid == QI'(q)),
      .tail(cq_tail[q]), .phase(cq_phase[q]), .live(cq_live[q]),
      .full_now(cq_full_now[q]), .full_q(cq_full[q]),
      .irq_q(irq_req[q]), .restart_q(restart_cq[q]));

    assign restart_sq[q] = sq_live[q] && restart_cq[sq_bind[q]];
  end

  always_comb begin
    fetch_slot = sq_head[fetch_sqid];
    post_ready = cq_live[post_cqid] && !cq_full_now[post_cqid];
    cqe_slot   = cq_tail[post_cqid];
    cqe_status = {post_code, cq_phase[post_cqid]};
  end

  // R8: a fetch restart is only ever raised alongside a posting restart
  assert_restart_pairs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_sq != '0) |-> (restart_cq != '0));
endmodule

// File: tb/qdb_tracker_test.sv
module qdb_tracker_test;
  localparam int NQ = 64, QW = 12, AW = 16, SW = 15, QI = 6;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0; logic [AW-1:0] wr_addr = '0; logic [31:0] wr_data = '0;
  logic cfg_en = 0, cfg_is_cq = 0, cfg_ien = 0;
  logic [QI-1:0] cfg_qid = '0, cfg_cqid = '0, fetch_sqid = '0, post_cqid = '0;
  logic [QW-1:0] cfg_qsize = '0;
  logic fetch_en = 0, post_valid = 0;
  logic [SW-1:0] post_code = '0;
  logic [QW-1:0] fetch_slot, cqe_slot;
  logic post_ready;
  logic [SW:0] cqe_status;
  logic [NQ-1:0] sq_empty, cq_full, irq_req, restart_cq, restart_sq;

  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  qdb_tracker #(.NQ(NQ), .QW(QW), .AW(AW), .SW(SW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_en(cfg_en), .cfg_is_cq(cfg_is_cq), .cfg_qid(cfg_qid), .cfg_qsize(cfg_qsize),
    .cfg_cqid(cfg_cqid), .cfg_ien(cfg_ien), .fetch_en(fetch_en), .fetch_sqid(fetch_sqid),
    .fetch_slot(fetch_slot), .post_valid(post_valid), .post_ready(post_ready),
    .post_cqid(post_cqid), .post_code(post_code), .cqe_status(cqe_status),
    .cqe_slot(cqe_slot), .sq_empty(sq_empty), .cq_full(cq_full), .irq_req(irq_req),
    .restart_cq(restart_cq), .restart_sq(restart_sq));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic eq(input string tag, input longint act, input longint exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic step;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic cfg_q(input bit is_cq, input int qid, input int qsize, input int cqid, input bit ien);
    cfg_en = 1; cfg_is_cq = is_cq; cfg_qid = QI'(qid); cfg_qsize = QW'(qsize);
    cfg_cqid = QI'(cqid); cfg_ien = ien;
    step; cfg_en = 0;
  endtask

  task automatic db(input int addr, input int data);
    wr_en = 1; wr_addr = AW'(addr); wr_data = data;
    step; wr_en = 0;
  endtask

  task automatic fetch(input int sq, input int exp_slot, input string tag);
    fetch_en = 1; fetch_sqid = QI'(sq); #1;
    eq(tag, fetch_slot, exp_slot);
    step; fetch_en = 0;
  endtask

  task automatic post(input int cq, input int code, input int exp_slot, input int exp_ph);
    post_valid = 1; post_cqid = QI'(cq); post_code = SW'(code); #1;
    eq("R6 post_ready before post", post_ready, 1);
    eq("R7 cqe_slot", cqe_slot, exp_slot);
    eq("R7 cqe_status", cqe_status, (code << 1) | exp_ph);
    step; post_valid = 0;
  endtask

  task automatic t_reset;
    post_cqid = 1; #1;
    eq("R1 sq_empty", sq_empty, {NQ{1'b1}});
    eq("R1 cq_full", cq_full, 0);
    eq("R1 post_ready", post_ready, 0);
    eq("R1 pulses", irq_req | restart_cq | restart_sq, 0);
  endtask

  task automatic t_setup;
    cfg_q(1, 1, 3, 0, 1);
    cfg_q(1, 0, 1, 0, 0);
    cfg_q(0, 1, 3, 1, 0);
    cfg_q(0, 2, 7, 1, 0);
    cfg_q(0, 0, 1, 0, 0);
    post_cqid = 1; #1;
    eq("R4 fresh cq ready", post_ready, 1);
    eq("R4 fresh cq slot", cqe_slot, 0);
    eq("R4 fresh phase", cqe_status[0], 1);
  endtask

  task automatic t_sq_tail;
    db(16'h1008, 32'hABCD_0003);
    eq("R10 sq_empty not yet updated", sq_empty[1], 1);
    step;
    eq("R2 sq tail doorbell", sq_empty[1], 0);
    fetch(1, 0, "R5 fetch slot0");
    fetch(1, 1, "R5 fetch slot1");
    fetch(1, 2, "R5 fetch slot2");
    step;
    eq("R5 empty after drain", sq_empty[1], 1);
    fetch(1, 3, "R5 fetch on empty");
    fetch_sqid = 1; #1;
    eq("R5 empty fetch ignored", fetch_slot, 3);
  endtask

  task automatic t_ignored;
    db(16'h100A, 1); step;
    eq("R2 misaligned ignored", sq_empty[1], 1);
    db(16'h1008, 4); step;
    eq("R3 value>=size ignored", sq_empty[1], 1);
    db(16'h1028, 1); step;
    fetch_sqid = 5; #1;
    eq("R3 absent queue ignored", fetch_slot, 0);
    db(16'h1008, 1); step;
    eq("R2 sq wrap tail", sq_empty[1], 0);
    fetch(1, 3, "R5 fetch slot3");
    fetch(1, 0, "R5 head wraps");
  endtask

  task automatic t_fill_drain;
    post(1, 5, 0, 1);
    post(1, 6, 1, 1);
    post(1, 7, 2, 1);
    post_valid = 0; post_cqid = 1; #1;
    eq("R6 full ready low", post_ready, 0);
    step;
    eq("R10 cq_full flag", cq_full[1], 1);
    db(16'h100C, 2);
    eq("R8 restart_cq1", restart_cq[1], 1);
    eq("R8 restart bound sqs", restart_sq[2:0], 3'b110);
    eq("R9 irq head!=tail", irq_req[1], 1);
    step;
    eq("R8 pulse one cycle", restart_cq[1], 0);
    post(1, 9, 3, 1);
    post(1, 7, 0, 0);
    post_cqid = 1; #1;
    eq("R6 full after wrap", post_ready, 0);
    db(16'h100C, 1);
    eq("R8 restart again", restart_cq[1], 1);
    eq("R9 no irq head==tail", irq_req[1], 0);
  endtask

  task automatic t_no_ien;
    post(0, 3, 0, 1);
    db(16'h1004, 0);
    eq("R8 restart cq0", restart_cq[0], 1);
    eq("R8 restart sq0 only", restart_sq[2:0], 3'b001);
    eq("R9 irq disabled", irq_req[0], 0);
    db(16'h1004, 2);
    post_cqid = 0; #1;
    eq("R3 oversize head ignored", post_ready, 0);
  endtask

  task automatic t_same_cycle;
    post(1, 1, 1, 0);
    wr_en = 1; wr_addr = 16'h100C; wr_data = 2;
    post(1, 2, 2, 0);
    wr_en = 0;
    eq("R10 irq on same-cycle", irq_req[1], 1);
    post_cqid = 1; #1;
    eq("R10 both applied slot", cqe_slot, 3);
    eq("R10 both applied ready", post_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_setup;
    t_sq_tail;
    t_ignored;
    t_fill_drain;
    t_no_ien;
    t_same_cycle;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule